// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block sits beside a processor core and decides which low-power state the core enters when it executes a sleep instruction. Two standby-control registers are sampled at that moment. Together they pick one of three depths: light sleep, deep sleep or standby. Each depth stops a different set of units. In every non-running state the core is held off from executing.

A pending interrupt returns the processor to running from any depth, and so does a reset. The units that depth had stopped are then released. The outputs are a state code, a core-halt level, a clock-stop enable for the timer, serial and performance-counter peripherals, and a halt for the DMA controller. The clock gating cells and the peripherals themselves live outside this block.

Top module: `sleep_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state code is 0 (running) and core_halt, periph_stop and dma_halt are all low.
- R2: In running, a sleep strobe with bit SEL_BIT (default 7) of stby_ctl_a set moves the state to 3 (standby) on the next clock edge, whatever stby_ctl_b holds.
- R3: In running, a sleep strobe with bit SEL_BIT of stby_ctl_a clear and bit SEL_BIT of stby_ctl_b set moves the state to 2 (deep sleep) on the next edge.
- R4: In running, a sleep strobe with bit SEL_BIT clear in both registers moves the state to 1 (light sleep) on the next edge.
- R5: In running without a sleep strobe, the state stays 0 whatever the control registers and irq_pend hold.
- R6: core_halt is high in exactly those cycles in which the state code is not 0.
- R7: periph_stop is high in a cycle exactly when the state code was 3 in the previous cycle.
- R8: dma_halt is high in a cycle exactly when the state code was 2 in the previous cycle.
- R9: In any sleep state (1, 2 or 3), irq_pend seen high at a clock edge returns the state to 0 on that edge, and the stop outputs of that depth fall one cycle later.
- R10: In any sleep state with irq_pend low, the sleep strobe and both control registers are ignored and the state does not change.
- R11: Only bit SEL_BIT of each control register affects the choice; all other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | One-cycle strobe from the core when it executes a sleep instruction |
| stby_ctl_a | input | CTL_W | First standby-control register; bit SEL_BIT selects standby |
| stby_ctl_b | input | CTL_W | Second standby-control register; bit SEL_BIT selects deep sleep |
| irq_pend | input | 1 | An interrupt is pending; wakes the processor |
| pwr_state | output | 2 | State code: 0 running, 1 light sleep, 2 deep sleep, 3 standby |
| core_halt | output | 1 | The core must not execute instructions |
| periph_stop | output | 1 | Clock-stop enable for timer, serial and performance-counter units |
| dma_halt | output | 1 | Halt for the DMA controller |

## Verification
The bench goes after the priority between the two selector bits when both are set. A design that ranked them the wrong way would settle in deep sleep where standby is due. It drives a sleep strobe together with toggled selector bits while the processor is already asleep. A design that re-sampled them would hop between depths without waking. It raises the interrupt in the very cycle a sleep strobe lands and sets only the non-selector bits of the registers. It also checks the single-cycle lag of the stop outputs on entry and on wake. A design that drove them straight from the next state, or held them after wake, would show a one-cycle mismatch.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_LIGHT = 2'd1,
        PS_DEEP  = 2'd2,
        PS_STBY  = 2'd3
    } pstate_e;

    typedef struct packed {
        pstate_e state;
    } fsm_regs_t;

    typedef struct packed {
        logic periph_stop;
        logic dma_halt;
    } stop_regs_t;

endpackage

// File: rtl/sleep_depth_sel.sv
module sleep_depth_sel
    import sleep_ctrl_pkg::*;
#(
    parameter int CTL_W   = 8,
    parameter int SEL_BIT = 7
) (
    input  logic [CTL_W-1:0] ctl_a,
    input  logic [CTL_W-1:0] ctl_b,
    output pstate_e          depth
);

    logic want_stby;
    logic want_deep;

    assign want_stby = ctl_a[SEL_BIT];
    assign want_deep = ctl_b[SEL_BIT];

    // The first register outranks the second.
    always_comb begin
        if (want_stby) begin
            depth = PS_STBY;
        end else if (want_deep) begin
            depth = PS_DEEP;
        end else begin
            depth = PS_LIGHT;
        end
    end

endmodule

// File: rtl/sleep_state_fsm.sv
module sleep_state_fsm
    import sleep_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sleep_req,
    input  logic    irq_pend,
    input  pstate_e depth,
    output pstate_e state
);

    fsm_regs_t r_d;
    fsm_regs_t r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.state == PS_RUN) begin
            if (sleep_req) begin
                r_d.state = depth;
            end
        end else if (irq_pend) begin
            r_d.state = PS_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: PS_RUN};
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;

endmodule

// File: rtl/sleep_stop_gen.sv
module sleep_stop_gen
    import sleep_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state,
    output logic    periph_stop,
    output logic    dma_halt
);

    stop_regs_t s_d;
    stop_regs_t s_q;

    always_comb begin
        s_d.periph_stop = (state == PS_STBY);
        s_d.dma_halt    = (state == PS_DEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign periph_stop = s_q.periph_stop;
    assign dma_halt    = s_q.dma_halt;

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import sleep_ctrl_pkg::*;
#(
    parameter int CTL_W   = 8,
    parameter int SEL_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic [CTL_W-1:0] stby_ctl_a,
    input  logic [CTL_W-1:0] stby_ctl_b,
    input  logic             irq_pend,
    output logic [1:0]       pwr_state,
    output logic             core_halt,
    output logic             periph_stop,
    output logic             dma_halt
);

    pstate_e depth;
    pstate_e state;

    sleep_depth_sel #(
        .CTL_W   (CTL_W),
        .SEL_BIT (SEL_BIT)
    ) u_sel (
        .ctl_a (stby_ctl_a),
        .ctl_b (stby_ctl_b),
        .depth (depth)
    );

    sleep_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .irq_pend  (irq_pend),
        .depth     (depth),
        .state     (state)
    );

    sleep_stop_gen u_stop (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .periph_stop (periph_stop),
        .dma_halt    (dma_halt)
    );

    assign pwr_state = state;
    assign core_halt = (state != PS_RUN);

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
    parameter int CTL_W   = 8,
    parameter int SEL_BIT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req,
    input logic [CTL_W-1:0] stby_ctl_a,
    input logic [CTL_W-1:0] stby_ctl_b,
    input logic             irq_pend,
    input logic [1:0]       pwr_state,
    input logic             core_halt,
    input logic             periph_stop,
    input logic             dma_halt
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (pwr_state == 2'd0 && !periph_stop && !dma_halt);
        end
    end

    assert_enter_stby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && stby_ctl_a[SEL_BIT]) |=> pwr_state == 2'd3);

    assert_enter_deep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && !stby_ctl_a[SEL_BIT] && stby_ctl_b[SEL_BIT])
        |=> pwr_state == 2'd2);

    assert_enter_light_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && !stby_ctl_a[SEL_BIT] && !stby_ctl_b[SEL_BIT])
        |=> pwr_state == 2'd1);

    assert_stay_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !sleep_req) |=> pwr_state == 2'd0);

    assert_halt_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req) |=> core_halt);

    assert_periph_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3) |=> periph_stop);

    assert_periph_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd3) |=> !periph_stop);

    assert_dma_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2) |=> dma_halt);

    assert_dma_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd2) |=> !dma_halt);

    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && irq_pend) |=> pwr_state == 2'd0);

    assert_hold_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && !irq_pend) |=> $stable(pwr_state));

endmodule

bind sleep_ctrl sleep_ctrl_chk #(
    .CTL_W   (CTL_W),
    .SEL_BIT (SEL_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .stby_ctl_a  (stby_ctl_a),
    .stby_ctl_b  (stby_ctl_b),
    .irq_pend    (irq_pend),
    .pwr_state   (pwr_state),
    .core_halt   (core_halt),
    .periph_stop (periph_stop),
    .dma_halt    (dma_halt)
);

// File: tb/sleep_ctrl_tb.sv
module sleep_ctrl_tb;

    localparam int CTL_W   = 8;
    localparam int SEL_BIT = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic [CTL_W-1:0] stby_ctl_a = '0;
    logic [CTL_W-1:0] stby_ctl_b = '0;
    logic             irq_pend = 1'b0;
    logic [1:0]       pwr_state;
    logic             core_halt;
    logic             periph_stop;
    logic             dma_halt;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_state = 2'd0;
    logic       exp_periph = 1'b0;
    logic       exp_dma = 1'b0;

    always #10 clk = ~clk;

    sleep_ctrl #(.CTL_W(CTL_W), .SEL_BIT(SEL_BIT)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .stby_ctl_a  (stby_ctl_a),
        .stby_ctl_b  (stby_ctl_b),
        .irq_pend    (irq_pend),
        .pwr_state   (pwr_state),
        .core_halt   (core_halt),
        .periph_stop (periph_stop),
        .dma_halt    (dma_halt)
    );

    function automatic logic [1:0] model_next(logic [1:0] cur, logic sr,
                                              logic [CTL_W-1:0] a, logic [CTL_W-1:0] b,
                                              logic irq);
        if (cur == 2'd0) begin
            if (!sr) return 2'd0;
            if (a[SEL_BIT]) return 2'd3;
            if (b[SEL_BIT]) return 2'd2;
            return 2'd1;
        end
        if (irq) return 2'd0;
        return cur;
    endfunction

    function automatic string state_tag(logic [1:0] cur, logic sr,
                                        logic [CTL_W-1:0] a, logic [CTL_W-1:0] b,
                                        logic irq);
        if (cur == 2'd0) begin
            if (!sr) return "R5";
            if (a[SEL_BIT]) return "R2";
            if (b[SEL_BIT]) return "R3";
            return "R4";
        end
        if (irq) return "R9";
        return "R10";
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(logic sr, logic [CTL_W-1:0] a, logic [CTL_W-1:0] b, logic irq);
        string tag;
        logic [1:0] prev;
        sleep_req  = sr;
        stby_ctl_a = a;
        stby_ctl_b = b;
        irq_pend   = irq;
        prev       = exp_state;
        tag        = state_tag(prev, sr, a, b, irq);
        exp_periph = (prev == 2'd3);
        exp_dma    = (prev == 2'd2);
        exp_state  = model_next(prev, sr, a, b, irq);
        @(negedge clk);
        check(tag, pwr_state, exp_state);
        check("R6", core_halt, exp_state != 2'd0);
        check("R7", periph_stop, exp_periph);
        check("R8", dma_halt, exp_dma);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check("R1", pwr_state, 0);
        check("R1", periph_stop, 0);
        check("R1", dma_halt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pwr_state, 0);
        check("R1", core_halt, 0);

        // R2: both bits set, standby wins; then wake
        step(1'b1, 8'h80, 8'h80, 1'b0);
        step(1'b0, 8'h00, 8'h00, 1'b0);
        step(1'b0, 8'h00, 8'h00, 1'b1);   // R9 wake from standby
        step(1'b0, 8'h00, 8'h00, 1'b0);
        // R3: deep sleep; R10 toggles ignored while asleep
        step(1'b1, 8'h00, 8'h80, 1'b0);
        step(1'b1, 8'h80, 8'h00, 1'b0);
        step(1'b1, 8'h00, 8'h00, 1'b0);
        step(1'b0, 8'hFF, 8'hFF, 1'b1);   // R9 wake from deep
        step(1'b0, 8'h00, 8'h00, 1'b0);
        // R4 and R11: non-selector bits set, light sleep
        step(1'b1, 8'h7F, 8'h7F, 1'b0);
        step(1'b1, 8'h80, 8'h80, 1'b0);
        step(1'b1, 8'h00, 8'h00, 1'b1);   // R9 wake from light, strobe ignored
        // R5: no strobe keeps running
        step(1'b0, 8'h80, 8'h80, 1'b1);
        // strobe and interrupt in the same cycle: enter, then wake
        step(1'b1, 8'h00, 8'h80, 1'b1);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b0, 8'h00, 8'h00, 1'b0);

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            logic sr;
            logic irq;
            logic [CTL_W-1:0] a;
            logic [CTL_W-1:0] b;
            sr  = ($urandom % 4) == 0;
            irq = ($urandom % 6) == 0;
            a   = CTL_W'($urandom);
            b   = CTL_W'($urandom);
            step(sr, a, b, irq);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule